// File: doc/BRIEF.md
# Valid-Tagged Three-Stage Pipeline

This block is a short synchronous pipeline that sits between a small input queue and a small output queue. Data written into the input queue pass through three combinational stage functions. Two registers separate the functions, and each register carries a valid tag next to its data.

The pipeline moves on every clock, whether or not new input is waiting. When the input queue is empty, an invalid tag is loaded and travels down as a bubble. Only valid tokens reach the output queue.

A single advance condition governs the whole structure. Either every register and both queue pointers step in a cycle, or none of the pipeline state changes. The pipeline freezes only when the second register holds a valid token and the output queue has no room for it. While it is frozen the input queue can still accept new writes, and the output queue can still be read.

The stage functions are simple placeholders: an increment, a doubling and an XOR with a constant. A consumer can therefore predict every result.

Top module: `vtag_pipe`

## Requirements
- R1: After reset both queues are empty and both stage registers are invalid: `empty_o` is 1 and `full_o` is 0.
- R2: With the pipeline idle, a word written on clock edge k makes `empty_o` fall after edge k+3 and not earlier. Stages one and two are loaded on edges k+1 and k+2, and the output queue on edge k+3.
- R3: Each result read from `pop_data_o` equals ((x + 1) * 2 mod 2^W) XOR K, where x is the word written and K is the constant parameter.
- R4: Every accepted word yields exactly one result, in write order. This holds with any gaps between writes: an empty input queue loads an invalid tag, and invalid tags never enter the output queue.
- R5: When stage two is valid and the output queue is full, the stage registers hold and nothing is taken from the input queue in that cycle.
- R6: With no reads, the block accepts exactly 2*DEPTH+2 words (10 at the default DEPTH of 4) before `full_o` rises. Neither queue ever holds more than DEPTH entries.
- R7: A write presented while `full_o` is 1 is discarded and never produces a result.
- R8: After a stall, reading the output queue lets the pipeline resume, and every held word is delivered in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Write strobe for the input queue |
| push_data_i | input | W | Word to write |
| full_o | output | 1 | Input queue is full; writes are ignored |
| pop_i | input | 1 | Read strobe for the output queue |
| pop_data_o | output | W | Head of the output queue |
| empty_o | output | 1 | Output queue has no result |

## Verification
The embedded assertions run on every cycle. They check the freeze condition: the stage registers hold and the input count does not fall. They also check that neither queue count exceeds its depth, that an empty input queue produces an invalid stage-one tag, and that a valid stage-one token becomes a valid, doubled stage-two token.

Other behaviours appear only in the bench's scenarios. These are the exact three-edge latency, the total capacity of ten words, the discarding of writes made while full, and in-order delivery across irregular write gaps and irregular reads.

// File: rtl/vtag_pipe.sv
module vtag_pipe #(
  parameter int W = 16,
  parameter int DEPTH = 4,
  parameter logic [W-1:0] K = 'h5A3C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] pop_data_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);

  logic [W-1:0]  imem [DEPTH];
  logic [W-1:0]  omem [DEPTH];
  logic [PW-1:0] in_wp, in_rp, out_wp, out_rp;
  logic [CW-1:0] in_cnt, out_cnt;
  logic          s1_v, s2_v;
  logic [W-1:0]  s1_d, s2_d;

  logic in_empty, in_full, out_empty, out_full;
  logic adv, in_enq, in_deq, out_enq, out_deq;
  logic [W-1:0] f1, f2, f3;

  assign in_empty  = (in_cnt == '0);
  assign in_full   = (in_cnt == DEPTH_C);
  assign out_empty = (out_cnt == '0);
  assign out_full  = (out_cnt == DEPTH_C);

  assign adv     = !(s2_v && out_full);
  assign in_enq  = push_i && !in_full;
  assign in_deq  = adv && !in_empty;
  assign out_enq = adv && s2_v;
  assign out_deq = pop_i && !out_empty;

  assign f1 = imem[in_rp] + W'(1);
  assign f2 = {s1_d[W-2:0], 1'b0};
  assign f3 = s2_d ^ K;

  assign full_o     = in_full;
  assign empty_o    = out_empty;
  assign pop_data_o = omem[out_rp];

  always_ff @(posedge clk) begin
    if (in_enq) imem[in_wp] <= push_data_i;
    if (out_enq) omem[out_wp] <= f3;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_wp <= '0; in_rp <= '0; in_cnt <= '0;
      out_wp <= '0; out_rp <= '0; out_cnt <= '0;
      s1_v <= 1'b0; s1_d <= '0;
      s2_v <= 1'b0; s2_d <= '0;
    end else begin
      if (in_enq) in_wp <= (in_wp == LAST_P) ? '0 : in_wp + PW'(1);
      if (in_deq) in_rp <= (in_rp == LAST_P) ? '0 : in_rp + PW'(1);
      in_cnt <= in_cnt + CW'(in_enq) - CW'(in_deq);
      if (out_enq) out_wp <= (out_wp == LAST_P) ? '0 : out_wp + PW'(1);
      if (out_deq) out_rp <= (out_rp == LAST_P) ? '0 : out_rp + PW'(1);
      out_cnt <= out_cnt + CW'(out_enq) - CW'(out_deq);
      if (adv) begin
        s1_v <= !in_empty;
        if (!in_empty) s1_d <= f1;
        s2_v <= s1_v;
        if (s1_v) s2_d <= f2;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && out_full) |=> (s2_v && $stable(s2_d) && $stable(s1_v) && $stable(s1_d))); // R5
  AST_STALL_NO_DEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && out_full) |=> (in_cnt >= $past(in_cnt))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt <= DEPTH_C) && (out_cnt <= DEPTH_C)); // R6
  AST_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_empty && !(s2_v && out_full)) |=> !s1_v); // R4
  AST_STAGE2_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !(s2_v && out_full)) |=> (s2_v && s2_d == W'($past(s1_d) * 2))); // R3
endmodule

// File: tb/sim_vtag_pipe.sv
module sim_vtag_pipe;
  localparam int W = 16;
  localparam logic [W-1:0] K = 16'h5A3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_i = 1'b0;
  logic [W-1:0] push_data_i = '0;
  logic full_o, pop_i, empty_o;
  logic [W-1:0] pop_data_o;

  int checks = 0;
  int fails = 0;
  bit pop_en = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] expq [$];

  always #10 clk = ~clk;

  vtag_pipe #(.W(W), .DEPTH(4), .K(K)) u0 (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .full_o(full_o), .pop_i(pop_i), .pop_data_o(pop_data_o), .empty_o(empty_o));

  function automatic logic [W-1:0] model(logic [W-1:0] x);
    logic [W-1:0] a;
    a = x + 16'd1;
    a = a * 16'd2;
    return a ^ K;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one write attempt per call; accepted only when full_o is low
  task automatic push_word(input logic [W-1:0] x, output bit acc);
    push_i = 1'b1;
    push_data_i = x;
    acc = !full_o;
    if (acc) expq.push_back(model(x));
    @(negedge clk);
    push_i = 1'b0;
  endtask

  // monitor: scoreboard pops and compares in order (R3, R4, R8)
  initial begin
    pop_i = 1'b0;
    forever begin
      @(negedge clk);
      if (pop_en && !empty_o && rst_n) begin
        if (expq.size() == 0) begin
          check(1'b0, "R4 extra result", pop_data_o, '0);
        end else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          check(pop_data_o == e, "R3/R4 result", pop_data_o, e);
        end
        pop_i = 1'b1;
      end else begin
        pop_i = 1'b0;
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit acc;
    int n_acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(empty_o == 1'b1, "R1 empty_o", W'(empty_o), W'(1));
    check(full_o == 1'b0, "R1 full_o", W'(full_o), W'(0));

    // R2 latency: write on edge k, visible after edge k+3
    push_word(16'h0010, acc);
    check(empty_o == 1'b1, "R2 after k", W'(empty_o), W'(1));
    @(negedge clk);
    check(empty_o == 1'b1, "R2 after k+1", W'(empty_o), W'(1));
    @(negedge clk);
    check(empty_o == 1'b1, "R2 after k+2", W'(empty_o), W'(1));
    @(negedge clk);
    check(empty_o == 1'b0, "R2 after k+3", W'(empty_o), W'(0));
    pop_en = 1'b1;
    repeat (3) @(negedge clk);

    // R4 bubbles: irregular gaps between writes
    for (int i = 0; i < 30; i++) begin
      push_word(16'(i * 37 + 5), acc);
      repeat (i % 3) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check(expq.size() == 0, "R4 all delivered", 16'(expq.size()), 0);

    // R6 capacity with no reads, R7 writes while full discarded
    pop_en = 1'b0;
    repeat (2) @(negedge clk);
    n_acc = 0;
    for (int i = 0; i < 12; i++) begin
      push_word(16'hF000 + 16'(i), acc);
      if (acc) n_acc++;
    end
    check(n_acc == 10, "R6 accepted count", 16'(n_acc), 16'd10);
    check(full_o == 1'b1, "R6 full_o", W'(full_o), W'(1));
    repeat (4) @(negedge clk);
    check(full_o == 1'b1, "R5 stall holds", W'(full_o), W'(1));

    // R8 resume: drain held words in order
    pop_en = 1'b1;
    repeat (30) @(negedge clk);
    check(expq.size() == 0, "R8 drained", 16'(expq.size()), 0);
    check(empty_o == 1'b1, "R7 no extra result", W'(empty_o), W'(1));
    check(full_o == 1'b0, "R8 input freed", W'(full_o), W'(0));

    // R4/R8 mixed: back-to-back writes with intermittent reads
    for (int i = 0; i < 40; i++) begin
      pop_en = (i % 5) < 2;
      push_word(16'(i * 911), acc);
    end
    pop_en = 1'b1;
    repeat (40) @(negedge clk);
    check(expq.size() == 0, "R4 mixed drained", 16'(expq.size()), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule